// File: doc/BRIEF.md
# Multicart Mapper Register and Mirroring Unit

This block holds the bank-switching state of a cartridge mapper that lets one cartridge carry games built for several simple discrete-logic banking boards. The CPU programs it in two steps. First it writes to the page at CPU addresses $5000-$5FFF, which picks one of four registers. Then it writes anywhere in $8000-$FFFF, which stores the data byte into the register that was picked. The four registers are a CHR bank, an inner PRG bank, a mode word and an outer PRG bank.

The block drives the two CHR RAM bank address lines and the nametable address line toward the console video RAM. The nametable line comes from a four-way multiplexer that is steered by the mirroring field. A write to either per-game bank register can also flip the low mirroring bit, but only while a one-screen layout is active. This copies the mirroring control of another board family. The inner bank, the PRG mode, the outer size and the outer bank are brought out as ports for the PRG address logic beside this block.

The CPU bus is seen through a one-cycle write strobe that has already been qualified by the CPU clock and the read/write line. The strobe comes with address bits 15:12 and the data byte.

Top module: `bankreg_mirror_unit`

## Requirements
- R1: A strobed write whose address bits 15:12 equal 4'h5 points the selector at a register. Data bit 7 picks the group (0 = per-game, 1 = per-cartridge) and data bit 0 picks the member: {bit7,bit0} = 00 CHR, 01 inner, 10 mode, 11 outer. The other data bits are ignored.
- R2: A strobed write with address bit 15 set stores the data into the selected register. The stored value is visible on the outputs one clock after the strobe edge. A strobed write to any other page (for example $4xxx, $6xxx, $7xxx) changes nothing.
- R3: The CHR register keeps data bits 1:0 and drives `chr_bank`.
- R4: The inner register keeps data bits 3:0 and drives `inner_bank`.
- R5: The mode register keeps data bits 1:0 as the mirroring field, bits 3:2 as the PRG mode and bits 5:4 as the outer size. Bits 7:6 are dropped.
- R6: `ciram_a10` is 0 for mirroring 0, 1 for mirroring 1, `ppu_a10` for mirroring 2 and `ppu_a11` for mirroring 3.
- R7: When the mirroring field is 0 or 1, a write to the CHR or inner register also copies data bit 4 into mirroring bit 0. When the field is 2 or 3, data bit 4 leaves the mode register unchanged.
- R8: The outer register keeps data bits OUTER_W-1:0, and OUTER_W may be 4, 6 or 8. Upper data bits beyond that width are discarded.
- R9: Without a write strobe, no register changes, whatever is on the address and data inputs.
- R10: The synchronous active-low reset sets the selector to the CHR register, CHR and inner to 0, the mode to 6'h0C (mirroring 0, PRG mode 3, outer size 0) and the outer bank to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one edge per CPU cycle |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_stb | input | 1 | One-cycle qualified CPU write strobe |
| cpu_a_hi | input | 4 | CPU address bits 15:12 |
| cpu_d | input | 8 | CPU data bus |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| chr_bank | output | 2 | CHR RAM bank address bits |
| inner_bank | output | 4 | Inner PRG bank |
| mirror_mode | output | 2 | Mirroring field of the mode register |
| prg_mode | output | 2 | PRG banking mode |
| outer_size | output | 2 | Outer bank size code |
| outer_bank | output | OUTER_W | Outer PRG bank |
| ciram_a10 | output | 1 | Nametable address line to video RAM |

## Verification
The bench walks the mirroring side path both ways. In a one-screen layout, a bank write must flip the nametable line. In vertical or horizontal layouts, a bank write with bit 4 set must leave it alone. A design that gated this path wrongly would show a one-screen line that never follows bank writes, or a two-screen layout that collapses. The bench drives selector bytes with noise in bits 6:1 and writes to pages next to both windows, so that a decoder looking at too many or too few bits would store into the wrong register. A second copy of the block with a four-bit outer bank shows whether the upper bits are dropped. A reset in the middle of the run, followed by a write with no selector write first, shows whether the selector really returns to the CHR register.

// File: rtl/mbr_pkg.sv
// Package: shared widths, encodings and the power-on mode for the
// multicart mapper register and mirroring unit.
// Assumes: eight-bit CPU data bus, address seen as its top nibble.
package mbr_pkg;

    localparam int DATA_W   = 8;
    localparam int AHI_W    = 4;
    localparam int CHR_W    = 2;
    localparam int INNER_W  = 4;
    localparam int MODE_W   = 6;
    localparam int SEL_W    = 2;
    localparam int NUM_REGS = 1 << SEL_W;
    localparam int MIR_BIT  = 4;   // data bit that feeds the mirroring side path

    localparam logic [AHI_W-1:0] SEL_PAGE = 4'h5;

    // Register identity as {group bit, member bit}
    typedef enum logic [SEL_W-1:0] {
        RID_CHR   = 2'b00,
        RID_INNER = 2'b01,
        RID_MODE  = 2'b10,
        RID_OUTER = 2'b11
    } rid_e;

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mir_e;

    typedef enum logic [1:0] {
        PRG_WIDE_A = 2'd0,
        PRG_WIDE_B = 2'd1,
        PRG_FIX_LO = 2'd2,
        PRG_FIX_HI = 2'd3
    } prg_e;

    typedef struct packed {
        logic [1:0] osize;
        prg_e       prg;
        mir_e       mir;
    } mode_t;

    // Fixed-upper-half mode with the smallest outer size and one-screen low
    localparam mode_t MODE_POR = '{osize: 2'b00, prg: PRG_FIX_HI, mir: MIR_ONE_LO};

    // True when the mirroring field selects a one-screen layout
    function automatic logic is_one_screen(input mir_e m);
        return (m == MIR_ONE_LO) || (m == MIR_ONE_HI);
    endfunction

endpackage

// File: rtl/mbr_decode.sv
// Module: mbr_decode
// Turns the qualified CPU write strobe and address nibble into two
// write enables: one for the selector page, one for the ROM window.
// Assumes: wr_stb is already qualified by the CPU clock and R/W low.
module mbr_decode
    import mbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [AHI_W-1:0] a_hi,
    output logic             sel_we,
    output logic             data_we
);

    // Window match for the selector page and the upper half of the map
    always_comb begin
        sel_we  = wr_stb && (a_hi == SEL_PAGE);
        data_we = wr_stb && a_hi[AHI_W-1];
    end

    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |-> !(sel_we || data_we)); // R9

    AST_OTHER_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_hi[AHI_W-1] && (a_hi != SEL_PAGE)) |-> !(sel_we || data_we)); // R2

endmodule

// File: rtl/mbr_regs.sv
// Module: mbr_regs
// Holds the selector and the four mapper registers, and carries the
// side path that lets bank writes rewrite the low mirroring bit while
// a one-screen layout is active.
// Assumes: sel_we and data_we are never high together.
module mbr_regs
    import mbr_pkg::*;
#(
    parameter int OUTER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we,
    input  logic               data_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [CHR_W-1:0]   chr_q,
    output logic [INNER_W-1:0] inner_q,
    output mode_t              mode_q,
    output logic [OUTER_W-1:0] outer_q
);

    localparam logic [OUTER_W-1:0] OUTER_POR = {OUTER_W{1'b1}};

    rid_e                sel_q;
    logic [NUM_REGS-1:0] reg_we;
    logic                bank_we;

    // One write enable per register, decoded from the held selector
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
        assign reg_we[g] = data_we && (sel_q == rid_e'(SEL_W'(g)));
    end

    assign bank_we = reg_we[RID_CHR] || reg_we[RID_INNER];

    // Selector: group from data bit 7, member from data bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= RID_CHR;
        else if (sel_we)
            sel_q <= rid_e'({wdata[DATA_W-1], wdata[0]});
    end

    // CHR bank register
    always_ff @(posedge clk) begin
        if (!rst_n)
            chr_q <= '0;
        else if (reg_we[RID_CHR])
            chr_q <= wdata[CHR_W-1:0];
    end

    // Inner PRG bank register
    always_ff @(posedge clk) begin
        if (!rst_n)
            inner_q <= '0;
        else if (reg_we[RID_INNER])
            inner_q <= wdata[INNER_W-1:0];
    end

    // Mode register, plus mirroring side path from bank writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_POR;
        else if (reg_we[RID_MODE])
            mode_q <= mode_t'(wdata[MODE_W-1:0]);
        else if (bank_we && is_one_screen(mode_q.mir))
            mode_q.mir <= mir_e'({1'b0, wdata[MIR_BIT]});
    end

    // Outer PRG bank register, width set by OUTER_W
    always_ff @(posedge clk) begin
        if (!rst_n)
            outer_q <= OUTER_POR;
        else if (reg_we[RID_OUTER])
            outer_q <= wdata[OUTER_W-1:0];
    end

    AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (sel_q == rid_e'({$past(wdata[DATA_W-1]), $past(wdata[0])}))); // R1

    AST_CHR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we[RID_CHR] |=> (chr_q == $past(wdata[CHR_W-1:0]))); // R3

    AST_INNER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we[RID_INNER] |=> (inner_q == $past(wdata[INNER_W-1:0]))); // R4

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we[RID_MODE] |=> (mode_q == $past(wdata[MODE_W-1:0]))); // R5

    AST_OUTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we[RID_OUTER] |=> (outer_q == $past(wdata[OUTER_W-1:0]))); // R8

    AST_SIDE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && !mode_q.mir[1]) |=>
            (mode_q.mir == mir_e'({1'b0, $past(wdata[MIR_BIT])})) && $stable(mode_q.prg)); // R7

    AST_SIDE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we && mode_q.mir[1]) |=> $stable(mode_q)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_we |=> ($stable(chr_q) && $stable(inner_q) && $stable(mode_q) && $stable(outer_q))); // R9

    AST_POR_STATE: assert property (@(posedge clk)
        !rst_n |=> ((sel_q == RID_CHR) && (chr_q == '0) && (inner_q == '0) &&
                    (mode_q == MODE_POR) && (outer_q == OUTER_POR))); // R10

endmodule

// File: rtl/mbr_mirror.sv
// Module: mbr_mirror
// Four-way nametable multiplexer: fixed low, fixed high, or one of
// two video address lines, steered by the mirroring field.
// Assumes: purely combinational path; clk/rst_n serve the checks only.
module mbr_mirror
    import mbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  mir_e mir,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic nt_a10
);

    // Pick the nametable line for the active layout
    always_comb begin
        unique case (mir)
            MIR_ONE_LO: nt_a10 = 1'b0;
            MIR_ONE_HI: nt_a10 = 1'b1;
            MIR_VERT:   nt_a10 = ppu_a10;
            MIR_HORZ:   nt_a10 = ppu_a11;
            default:    nt_a10 = 1'b0;
        endcase
    end

    AST_ONE_SCREEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        is_one_screen(mir) |-> (nt_a10 == mir[0])); // R6

    AST_TWO_SCREEN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !is_one_screen(mir) |-> (nt_a10 == (mir[0] ? ppu_a11 : ppu_a10))); // R6

endmodule

// File: rtl/bankreg_mirror_unit.sv
// Module: bankreg_mirror_unit
// Top of the multicart mapper register and mirroring unit: decodes
// CPU writes, holds the four mapper registers and drives the CHR bank
// and nametable address lines.
// Assumes: OUTER_W is 4, 6 or 8; state survives anything but rst_n.
module bankreg_mirror_unit
    import mbr_pkg::*;
#(
    parameter int OUTER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [AHI_W-1:0]   cpu_a_hi,
    input  logic [DATA_W-1:0]  cpu_d,
    input  logic               ppu_a10,
    input  logic               ppu_a11,
    output logic [CHR_W-1:0]   chr_bank,
    output logic [INNER_W-1:0] inner_bank,
    output logic [1:0]         mirror_mode,
    output logic [1:0]         prg_mode,
    output logic [1:0]         outer_size,
    output logic [OUTER_W-1:0] outer_bank,
    output logic               ciram_a10
);

    logic  sel_we;
    logic  data_we;
    mode_t mode_q;

    mbr_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .a_hi    (cpu_a_hi),
        .sel_we  (sel_we),
        .data_we (data_we)
    );

    mbr_regs #(.OUTER_W(OUTER_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_we  (sel_we),
        .data_we (data_we),
        .wdata   (cpu_d),
        .chr_q   (chr_bank),
        .inner_q (inner_bank),
        .mode_q  (mode_q),
        .outer_q (outer_bank)
    );

    mbr_mirror u_mirror (
        .clk     (clk),
        .rst_n   (rst_n),
        .mir     (mode_q.mir),
        .ppu_a10 (ppu_a10),
        .ppu_a11 (ppu_a11),
        .nt_a10  (ciram_a10)
    );

    // Break the mode word out onto its field ports
    always_comb begin
        mirror_mode = mode_q.mir;
        prg_mode    = mode_q.prg;
        outer_size  = mode_q.osize;
    end

    AST_OUTER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (OUTER_W == 4) || (OUTER_W == 6) || (OUTER_W == 8)); // R8

endmodule

// File: tb/sim_bankreg_mirror_unit.sv
`timescale 1ns/1ps
module sim_bankreg_mirror_unit;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        a10;
        logic        a11;
        logic [1:0]  chr;
        logic [3:0]  inner;
        logic [5:0]  mode;
        logic [7:0]  outer;
        logic        nt;
    } vec_t;

    localparam int NV = 24;
    // wr, addr, data, a10, a11 | expected chr, inner, mode, outer, nt
    localparam vec_t VT [NV] = '{
        '{1'b1, 16'h5000, 8'h00, 1'b1, 1'b0, 2'd0, 4'h0, 6'h0C, 8'hFF, 1'b0}, // select CHR (R1)
        '{1'b1, 16'h8000, 8'h13, 1'b1, 1'b0, 2'd3, 4'h0, 6'h0D, 8'hFF, 1'b1}, // CHR + side path
        '{1'b1, 16'h5FFF, 8'h01, 1'b1, 1'b0, 2'd3, 4'h0, 6'h0D, 8'hFF, 1'b1}, // select inner
        '{1'b1, 16'hC123, 8'h0A, 1'b1, 1'b0, 2'd3, 4'hA, 6'h0C, 8'hFF, 1'b0}, // inner, bit4 = 0
        '{1'b1, 16'h5000, 8'h80, 1'b1, 1'b0, 2'd3, 4'hA, 6'h0C, 8'hFF, 1'b0}, // select mode
        '{1'b1, 16'hFFFF, 8'h3E, 1'b1, 1'b0, 2'd3, 4'hA, 6'h3E, 8'hFF, 1'b1}, // vertical
        '{1'b1, 16'h5000, 8'h00, 1'b0, 1'b1, 2'd3, 4'hA, 6'h3E, 8'hFF, 1'b0},
        '{1'b1, 16'h8000, 8'h11, 1'b0, 1'b1, 2'd1, 4'hA, 6'h3E, 8'hFF, 1'b0}, // bit4 ignored
        '{1'b1, 16'h5000, 8'h81, 1'b0, 1'b1, 2'd1, 4'hA, 6'h3E, 8'hFF, 1'b0}, // select outer
        '{1'b1, 16'h9000, 8'h5A, 1'b1, 1'b1, 2'd1, 4'hA, 6'h3E, 8'h5A, 1'b1},
        '{1'b1, 16'h5000, 8'h80, 1'b1, 1'b0, 2'd1, 4'hA, 6'h3E, 8'h5A, 1'b1},
        '{1'b1, 16'h8000, 8'h03, 1'b1, 1'b0, 2'd1, 4'hA, 6'h03, 8'h5A, 1'b0}, // horizontal
        '{1'b0, 16'h8000, 8'h00, 1'b0, 1'b1, 2'd1, 4'hA, 6'h03, 8'h5A, 1'b1}, // no strobe (R9)
        '{1'b1, 16'h7000, 8'hFF, 1'b0, 1'b1, 2'd1, 4'hA, 6'h03, 8'h5A, 1'b1}, // other page (R2)
        '{1'b1, 16'h4444, 8'hFF, 1'b0, 1'b1, 2'd1, 4'hA, 6'h03, 8'h5A, 1'b1}, // other page
        '{1'b1, 16'h5000, 8'h7F, 1'b0, 1'b1, 2'd1, 4'hA, 6'h03, 8'h5A, 1'b1}, // noisy select inner
        '{1'b1, 16'h8000, 8'hF6, 1'b0, 1'b1, 2'd1, 4'h6, 6'h03, 8'h5A, 1'b1}, // bit4 ignored
        '{1'b1, 16'h5000, 8'hFE, 1'b0, 1'b0, 2'd1, 4'h6, 6'h03, 8'h5A, 1'b0}, // noisy select mode
        '{1'b1, 16'hA000, 8'h01, 1'b0, 1'b0, 2'd1, 4'h6, 6'h01, 8'h5A, 1'b1}, // one-screen high
        '{1'b1, 16'h5000, 8'h01, 1'b0, 1'b0, 2'd1, 4'h6, 6'h01, 8'h5A, 1'b1},
        '{1'b1, 16'h8000, 8'h05, 1'b0, 1'b0, 2'd1, 4'h5, 6'h00, 8'h5A, 1'b0}, // side path clears
        '{1'b1, 16'h5000, 8'h00, 1'b1, 1'b1, 2'd1, 4'h5, 6'h00, 8'h5A, 1'b0},
        '{1'b1, 16'h8000, 8'h12, 1'b1, 1'b1, 2'd2, 4'h5, 6'h01, 8'h5A, 1'b1}, // side path sets
        '{1'b1, 16'h6000, 8'hAA, 1'b1, 1'b1, 2'd2, 4'h5, 6'h01, 8'h5A, 1'b1}  // other page
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [3:0] cpu_a_hi = 4'h0;
    logic [7:0] cpu_d = 8'h00;
    logic       ppu_a10 = 1'b0;
    logic       ppu_a11 = 1'b0;

    logic [1:0] chr_bank, chr_b;
    logic [3:0] inner_bank, inner_b;
    logic [1:0] mirror_mode, mirror_b, prg_mode, prg_b, outer_size, osize_b;
    logic [7:0] outer_bank;
    logic [3:0] outer_b;
    logic       ciram_a10, ciram_b;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    bankreg_mirror_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cpu_a_hi(cpu_a_hi), .cpu_d(cpu_d),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .chr_bank(chr_bank), .inner_bank(inner_bank),
        .mirror_mode(mirror_mode), .prg_mode(prg_mode), .outer_size(outer_size),
        .outer_bank(outer_bank), .ciram_a10(ciram_a10)
    );

    // Narrow copy: four-bit outer bank
    bankreg_mirror_unit #(.OUTER_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cpu_a_hi(cpu_a_hi), .cpu_d(cpu_d),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .chr_bank(chr_b), .inner_bank(inner_b),
        .mirror_mode(mirror_b), .prg_mode(prg_b), .outer_size(osize_b),
        .outer_bank(outer_b), .ciram_a10(ciram_b)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, strobe spans one rising edge
    task automatic bus(input logic w, input logic [15:0] a, input logic [7:0] d,
                       input logic v10, input logic v11);
        @(negedge clk);
        wr_stb = w; cpu_a_hi = a[15:12]; cpu_d = d; ppu_a10 = v10; ppu_a11 = v11;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic chk_all(input string tag, input logic [1:0] c, input logic [3:0] i,
                           input logic [5:0] m, input logic [7:0] o, input logic n);
        chk({tag, " R3"}, "chr_bank", 32'(chr_bank), 32'(c));
        chk({tag, " R4"}, "inner_bank", 32'(inner_bank), 32'(i));
        chk({tag, " R5 R7"}, "mode", 32'({outer_size, prg_mode, mirror_mode}), 32'(m));
        chk({tag, " R8"}, "outer_bank", 32'(outer_bank), 32'(o));
        chk({tag, " R8"}, "narrow outer_bank", 32'(outer_b), 32'(o[3:0]));
        chk({tag, " R6"}, "ciram_a10", 32'(ciram_a10), 32'(n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: power-on state
        chk_all("R10 por", 2'd0, 4'h0, 6'h0C, 8'hFF, 1'b0);

        for (int k = 0; k < NV; k++) begin
            bus(VT[k].wr, VT[k].addr, VT[k].data, VT[k].a10, VT[k].a11);
            chk_all($sformatf("vec%0d", k), VT[k].chr, VT[k].inner, VT[k].mode, VT[k].outer, VT[k].nt);
        end

        // R9: idle cycles with busy inputs change nothing
        for (int k = 0; k < 6; k++) begin
            bus(1'b0, 16'h8000 | 16'(k << 12), 8'(8'h3F + k), 1'b1, 1'b1);
        end
        chk_all("R9 idle", 2'd2, 4'h5, 6'h01, 8'h5A, 1'b1);

        // R10: reset in mid-run restores defaults and the selector
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_all("R10 rerst", 2'd0, 4'h0, 6'h0C, 8'hFF, 1'b0);
        bus(1'b1, 16'h8000, 8'h02, 1'b1, 1'b1);
        chk("R10", "selector after reset -> chr_bank", 32'(chr_bank), 32'd2);
        chk("R7", "mode after bit4=0 write", 32'({outer_size, prg_mode, mirror_mode}), 32'h0C);

        // R1: noisy selector byte 0x81 with middle bits set -> still outer
        bus(1'b1, 16'h5ABC, 8'hBD, 1'b0, 1'b0);
        bus(1'b1, 16'hE000, 8'hC3, 1'b0, 1'b0);
        chk("R1", "outer_bank via noisy select", 32'(outer_bank), 32'hC3);
        chk("R8", "narrow outer drops upper bits", 32'(outer_b), 32'h3);

        // R2: write to $4FFF and $7FFF pages leaves outer alone
        bus(1'b1, 16'h4FFF, 8'h11, 1'b0, 1'b0);
        bus(1'b1, 16'h7FFF, 8'h22, 1'b0, 1'b0);
        chk("R2", "outer_bank after off-window writes", 32'(outer_bank), 32'hC3);

        // R5: bits 7:6 of a mode write are dropped
        bus(1'b1, 16'h5000, 8'h80, 1'b0, 1'b0);
        bus(1'b1, 16'h8000, 8'hE6, 1'b1, 1'b0);
        chk("R5", "mode drops bits 7:6", 32'({outer_size, prg_mode, mirror_mode}), 32'h26);
        chk("R6", "vertical follows ppu_a10", 32'(ciram_a10), 32'd1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule